// File: doc/BRIEF.md
# Dual-CPU doorbell channel controller

The block links two processors through one-bit doorbell channels. There are sixteen channels in each direction. Each processor has its own synchronous register port and its own interrupt line. A processor rings channel x by writing 1 to its send bit. This makes the receiver's incoming bit and its incoming-flag status go high. The receiver acknowledges by writing 1 to that status bit, which clears it. The acknowledgement frees the channel on both sides and raises a completion (send-empty) status on the sender. The message itself is held in memory outside the block. The doorbell only tells the receiver that it is there and tells the sender when it has been consumed.

Each side sees four 32-bit registers, selected by byte address bits [3:2]:

| Offset | Register | Upper half [31:16] | Lower half [15:0] |
|---|---|---|---|
| 0x0 | Data | Send bits, set by writing 1 | Live view of the peer's send bits, read-only |
| 0x4 | Status | Send-empty status | Incoming-flag status |
| 0x8 | Mask | Send-empty enables | Incoming-flag enables |
| 0xC | Clear | Write 1 to bit 16+x to force send bit x to clear; reads 0 | Reserved |

Status bits are cleared by writing 1. A mask bit of 1 enables the matching interrupt. Reads are combinational from the current register state and have no side effects.

Top module: `doorbell_pair`

## Requirements
- R1: After reset every register field on both sides reads 0 and both interrupt outputs are low.
- R2: Data register (0x0): bit 16+x is the side's send bit x, and bit x shows the peer's send bit x. Writing 0 to any bit has no effect. Writes to bits [15:0] are ignored.
- R3: Writing 1 to a free send bit x does three things at the next edge: it sets that send bit, it sets the peer's incoming-flag status bit x (the peer's view bit x follows), and it clears the sender's send-empty status bit x.
- R4: Status register (0x4): send-empty status x is at bit 16+x and incoming-flag status x is at bit x. Writing 1 clears a bit and writing 0 leaves it unchanged.
- R5: Clearing an incoming-flag status bit x that is set releases the channel. The sender's send bit x clears, so the receiver's view bit x also clears, and the sender's send-empty status bit x is set. Writing 1 to an incoming-flag bit that is already clear releases nothing.
- R6: Mask register (0x8) is read/write. Bit 16+x enables send-empty interrupt x and bit x enables incoming-flag interrupt x.
- R7: Each interrupt output is a register that holds the OR of (status AND mask) for its side. It rises one cycle after a status update that enables it, and falls one cycle after the last enabled status bit clears.
- R8: Clear register (0xC): writing 1 to bit 16+x clears the side's send bit x. It leaves every status bit unchanged. Writing 0 has no effect, and the register reads 0.
- R9: When a set event and a software clear hit the same status or send bit in one cycle, the set wins.
- R10: Writing 1 to a send bit that is already set has no effect. In particular, it does not clear the send-empty status.
- R11: The two directions and all sixteen channels work independently of one another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| a_wr_en_i | input | 1 | Side A register write strobe |
| a_addr_i | input | ADDR_W | Side A byte address |
| a_wdata_i | input | 32 | Side A write data |
| a_rdata_o | output | 32 | Side A read data for a_addr_i |
| a_irq_o | output | 1 | Side A interrupt |
| b_wr_en_i | input | 1 | Side B register write strobe |
| b_addr_i | input | ADDR_W | Side B byte address |
| b_wdata_i | input | 32 | Side B write data |
| b_rdata_o | output | 32 | Side B read data for b_addr_i |
| b_irq_o | output | 1 | Side B interrupt |

## Verification
The properties assume only that both ports carry known values once reset is released. Both sides may write in the same cycle, to any register, with any data. The stimulus applies each write for exactly one clock, with inputs changed at the falling edge. It includes deliberate collisions: a ring together with a release, and a send-empty clear together with a release, on the same channel. This exercises the set-wins rule that the properties rely on.

// File: rtl/doorbell_pkg.sv
package doorbell_pkg;
  localparam int unsigned REG_W  = 32;
  localparam int unsigned HALF_W = 16;

  typedef enum logic [1:0] {
    SEL_DATA = 2'd0,
    SEL_STAT = 2'd1,
    SEL_MASK = 2'd2,
    SEL_KILL = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/doorbell_regdec.sv
module doorbell_regdec
  import doorbell_pkg::*;
#(
  parameter int unsigned ADDR_W = 4
) (
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  output reg_sel_e          sel_o,
  output logic              wr_data_o,
  output logic              wr_stat_o,
  output logic              wr_mask_o,
  output logic              wr_kill_o
);
  logic unused_addr;
  assign unused_addr = ^addr_i[1:0];

  assign sel_o = reg_sel_e'(addr_i[3:2]);

  always_comb begin
    wr_data_o = 1'b0;
    wr_stat_o = 1'b0;
    wr_mask_o = 1'b0;
    wr_kill_o = 1'b0;
    if (wr_en_i) begin
      unique case (sel_o)
        SEL_DATA: wr_data_o = 1'b1;
        SEL_STAT: wr_stat_o = 1'b1;
        SEL_MASK: wr_mask_o = 1'b1;
        SEL_KILL: wr_kill_o = 1'b1;
        default:  ;
      endcase
    end
  end
endmodule

// File: rtl/doorbell_chan.sv
// One channel slice of one side: send bit, send-empty and incoming-flag status.
module doorbell_chan (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ring_req_i,   // write 1 to send bit
  input  logic clr_txe_i,    // w1c send-empty
  input  logic clr_rxf_i,    // w1c incoming-flag
  input  logic kill_i,       // forced send clear
  input  logic peer_ring_i,  // peer rang this channel
  input  logic peer_ack_i,   // peer released our send
  output logic tx_o,
  output logic txe_o,
  output logic rxf_o,
  output logic ring_o,
  output logic ack_o
);
  logic tx_q, txe_q, rxf_q;

  // a busy channel ignores a second ring
  assign ring_o = ring_req_i & ~tx_q;
  // only a real clear of a set flag releases the sender
  assign ack_o  = clr_rxf_i & rxf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_q  <= 1'b0;
      txe_q <= 1'b0;
      rxf_q <= 1'b0;
    end else begin
      // set terms listed first: set wins over any clear
      tx_q  <= ring_o      | (tx_q  & ~peer_ack_i & ~kill_i);
      txe_q <= peer_ack_i  | (txe_q & ~clr_txe_i  & ~ring_o);
      rxf_q <= peer_ring_i | (rxf_q & ~clr_rxf_i);
    end
  end

  assign tx_o  = tx_q;
  assign txe_o = txe_q;
  assign rxf_o = rxf_q;
endmodule

// File: rtl/doorbell_irq.sv
module doorbell_irq #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] stat_i,
  input  logic [WIDTH-1:0] mask_i,
  output logic             irq_o
);
  logic irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= |(stat_i & mask_i);
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/doorbell_side.sv
module doorbell_side
  import doorbell_pkg::*;
#(
  parameter int unsigned NUM_CH = 16,
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [REG_W-1:0]  wdata_i,
  output logic [REG_W-1:0]  rdata_o,
  output logic              irq_o,
  input  logic [NUM_CH-1:0] peer_tx_i,
  input  logic [NUM_CH-1:0] peer_ring_i,
  input  logic [NUM_CH-1:0] peer_ack_i,
  output logic [NUM_CH-1:0] tx_o,
  output logic [NUM_CH-1:0] ring_o,
  output logic [NUM_CH-1:0] ack_o,
  output logic [NUM_CH-1:0] kill_o,
  output logic [NUM_CH-1:0] txe_o,
  output logic [NUM_CH-1:0] rxf_o
);
  localparam int unsigned IRQ_W = 2 * NUM_CH;

  reg_sel_e          sel;
  logic              wr_data, wr_stat, wr_mask, wr_kill;
  logic [NUM_CH-1:0] tx, txe, rxf, mtx_q, mrx_q;
  logic [HALF_W-1:0] tx_h, ptx_h, txe_h, rxf_h, mtx_h, mrx_h;

  doorbell_regdec #(.ADDR_W(ADDR_W)) i_regdec (
    .wr_en_i   (wr_en_i),
    .addr_i    (addr_i),
    .sel_o     (sel),
    .wr_data_o (wr_data),
    .wr_stat_o (wr_stat),
    .wr_mask_o (wr_mask),
    .wr_kill_o (wr_kill)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic kill;
    assign kill = wr_kill & wdata_i[HALF_W+i];

    doorbell_chan i_chan (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .ring_req_i  (wr_data & wdata_i[HALF_W+i]),
      .clr_txe_i   (wr_stat & wdata_i[HALF_W+i]),
      .clr_rxf_i   (wr_stat & wdata_i[i]),
      .kill_i      (kill),
      .peer_ring_i (peer_ring_i[i]),
      .peer_ack_i  (peer_ack_i[i]),
      .tx_o        (tx[i]),
      .txe_o       (txe[i]),
      .rxf_o       (rxf[i]),
      .ring_o      (ring_o[i]),
      .ack_o       (ack_o[i])
    );
    assign kill_o[i] = kill;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mtx_q <= '0;
      mrx_q <= '0;
    end else if (wr_mask) begin
      mtx_q <= wdata_i[HALF_W +: NUM_CH];
      mrx_q <= wdata_i[NUM_CH-1:0];
    end
  end

  // widen channel vectors to register halves
  for (genvar i = 0; i < HALF_W; i++) begin : g_pad
    if (i < NUM_CH) begin : g_used
      assign tx_h[i]  = tx[i];
      assign ptx_h[i] = peer_tx_i[i];
      assign txe_h[i] = txe[i];
      assign rxf_h[i] = rxf[i];
      assign mtx_h[i] = mtx_q[i];
      assign mrx_h[i] = mrx_q[i];
    end else begin : g_zero
      assign tx_h[i]  = 1'b0;
      assign ptx_h[i] = 1'b0;
      assign txe_h[i] = 1'b0;
      assign rxf_h[i] = 1'b0;
      assign mtx_h[i] = 1'b0;
      assign mrx_h[i] = 1'b0;
    end
  end

  always_comb begin
    unique case (sel)
      SEL_DATA: rdata_o = {tx_h, ptx_h};
      SEL_STAT: rdata_o = {txe_h, rxf_h};
      SEL_MASK: rdata_o = {mtx_h, mrx_h};
      default:  rdata_o = '0;
    endcase
  end

  doorbell_irq #(.WIDTH(IRQ_W)) i_irq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .stat_i ({txe, rxf}),
    .mask_i ({mtx_q, mrx_q}),
    .irq_o  (irq_o)
  );

  assign tx_o  = tx;
  assign txe_o = txe;
  assign rxf_o = rxf;
endmodule

// File: rtl/doorbell_pair.sv
module doorbell_pair
  import doorbell_pkg::*;
#(
  parameter int unsigned NUM_CH = 16,
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              a_wr_en_i,
  input  logic [ADDR_W-1:0] a_addr_i,
  input  logic [REG_W-1:0]  a_wdata_i,
  output logic [REG_W-1:0]  a_rdata_o,
  output logic              a_irq_o,
  input  logic              b_wr_en_i,
  input  logic [ADDR_W-1:0] b_addr_i,
  input  logic [REG_W-1:0]  b_wdata_i,
  output logic [REG_W-1:0]  b_rdata_o,
  output logic              b_irq_o
);
  logic [NUM_CH-1:0] a_tx, a_ring, a_ack, a_kill, a_txe, a_rxf;
  logic [NUM_CH-1:0] b_tx, b_ring, b_ack, b_kill, b_txe, b_rxf;

  doorbell_side #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) i_side_a (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (a_wr_en_i),
    .addr_i      (a_addr_i),
    .wdata_i     (a_wdata_i),
    .rdata_o     (a_rdata_o),
    .irq_o       (a_irq_o),
    .peer_tx_i   (b_tx),
    .peer_ring_i (b_ring),
    .peer_ack_i  (b_ack),
    .tx_o        (a_tx),
    .ring_o      (a_ring),
    .ack_o       (a_ack),
    .kill_o      (a_kill),
    .txe_o       (a_txe),
    .rxf_o       (a_rxf)
  );

  doorbell_side #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) i_side_b (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (b_wr_en_i),
    .addr_i      (b_addr_i),
    .wdata_i     (b_wdata_i),
    .rdata_o     (b_rdata_o),
    .irq_o       (b_irq_o),
    .peer_tx_i   (a_tx),
    .peer_ring_i (a_ring),
    .peer_ack_i  (a_ack),
    .tx_o        (b_tx),
    .ring_o      (b_ring),
    .ack_o       (b_ack),
    .kill_o      (b_kill),
    .txe_o       (b_txe),
    .rxf_o       (b_rxf)
  );
endmodule

// File: rtl/doorbell_pair_chk.sv
module doorbell_pair_chk #(
  parameter int unsigned NUM_CH = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              a_irq_i,
  input logic              b_irq_i,
  input logic [NUM_CH-1:0] a_tx_i, a_ring_i, a_ack_i, a_kill_i, a_txe_i, a_rxf_i,
  input logic [NUM_CH-1:0] b_tx_i, b_ring_i, b_ack_i, b_kill_i, b_txe_i, b_rxf_i
);
  for (genvar i = 0; i < NUM_CH; i++) begin : g_p
    // R3: accepted ring busies the channel and flags the peer
    p_ring_sets_a_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      a_ring_i[i] |=> a_tx_i[i] && b_rxf_i[i]);
    p_ring_sets_b_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      b_ring_i[i] |=> b_tx_i[i] && a_rxf_i[i]);
    p_ring_txe_a_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      a_ring_i[i] && !b_ack_i[i] |=> !a_txe_i[i]);
    p_ring_txe_b_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      b_ring_i[i] && !a_ack_i[i] |=> !b_txe_i[i]);
    // R2: send bit only rises through an accepted ring
    p_tx_rise_a_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(a_tx_i[i]) |-> $past(a_ring_i[i]));
    p_tx_rise_b_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(b_tx_i[i]) |-> $past(b_ring_i[i]));
    // R5: release frees sender and raises send-empty
    p_ack_free_a_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      b_ack_i[i] && !a_ring_i[i] |=> !a_tx_i[i]);
    p_ack_free_b_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      a_ack_i[i] && !b_ring_i[i] |=> !b_tx_i[i]);
    // R9: set events win over same-cycle clears
    p_ack_txe_a_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      b_ack_i[i] |=> a_txe_i[i]);
    p_ack_txe_b_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      a_ack_i[i] |=> b_txe_i[i]);
    // R10: busy channel holds until released or forced clear
    p_busy_hold_a_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      a_tx_i[i] && !b_ack_i[i] && !a_kill_i[i] |=> a_tx_i[i]);
    p_busy_hold_b_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      b_tx_i[i] && !a_ack_i[i] && !b_kill_i[i] |=> b_tx_i[i]);
  end

  // R7: no status pending one cycle earlier means no interrupt
  p_irq_quiet_a_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(|{a_txe_i, a_rxf_i}) |-> !a_irq_i);
  p_irq_quiet_b_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(|{b_txe_i, b_rxf_i}) |-> !b_irq_i);
endmodule

bind doorbell_pair doorbell_pair_chk #(.NUM_CH(NUM_CH)) i_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .a_irq_i  (a_irq_o),
  .b_irq_i  (b_irq_o),
  .a_tx_i   (a_tx),
  .a_ring_i (a_ring),
  .a_ack_i  (a_ack),
  .a_kill_i (a_kill),
  .a_txe_i  (a_txe),
  .a_rxf_i  (a_rxf),
  .b_tx_i   (b_tx),
  .b_ring_i (b_ring),
  .b_ack_i  (b_ack),
  .b_kill_i (b_kill),
  .b_txe_i  (b_txe),
  .b_rxf_i  (b_rxf)
);

// File: tb/test_doorbell_pair.sv
`timescale 1ns/1ps
module test_doorbell_pair;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        a_we, b_we;
  logic [3:0]  a_addr, b_addr;
  logic [31:0] a_wd, b_wd, a_rd, b_rd;
  logic        a_irq, b_irq;

  always #10 clk = ~clk;

  doorbell_pair #(.NUM_CH(16), .ADDR_W(4)) i_doorbell_pair (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .a_wr_en_i (a_we),
    .a_addr_i  (a_addr),
    .a_wdata_i (a_wd),
    .a_rdata_o (a_rd),
    .a_irq_o   (a_irq),
    .b_wr_en_i (b_we),
    .b_addr_i  (b_addr),
    .b_wdata_i (b_wd),
    .b_rdata_o (b_rd),
    .b_irq_o   (b_irq)
  );

  int checks = 0;
  int errors = 0;

  // bench model, index 0 = side A, 1 = side B
  logic [15:0] m_tx [2];
  logic [15:0] m_txe[2];
  logic [15:0] m_rxf[2];
  logic [15:0] m_mtx[2];
  logic [15:0] m_mrx[2];
  logic        m_irq[2];

  task automatic cmp(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic irq_of(int s);
    return |({m_txe[s], m_rxf[s]} & {m_mtx[s], m_mrx[s]});
  endfunction

  // one write cycle on either or both sides; model follows the requirements
  task automatic op(logic wa, logic [3:0] aa, logic [31:0] da,
                    logic wb, logic [3:0] ab, logic [31:0] db);
    logic        we[2];
    logic [1:0]  rs[2];
    logic [31:0] wd[2];
    logic [15:0] ring[2], ack[2], kill[2], ctxe[2], crxf[2];
    a_we = wa; a_addr = aa; a_wd = da;
    b_we = wb; b_addr = ab; b_wd = db;
    we[0] = wa; rs[0] = aa[3:2]; wd[0] = da;
    we[1] = wb; rs[1] = ab[3:2]; wd[1] = db;
    @(posedge clk);
    for (int s = 0; s < 2; s++) begin
      m_irq[s] = irq_of(s);
      ring[s] = (we[s] && rs[s] == 2'd0) ? (wd[s][31:16] & ~m_tx[s]) : 16'h0;
      ack[s]  = (we[s] && rs[s] == 2'd1) ? (wd[s][15:0] & m_rxf[s]) : 16'h0;
      ctxe[s] = (we[s] && rs[s] == 2'd1) ? wd[s][31:16] : 16'h0;
      crxf[s] = (we[s] && rs[s] == 2'd1) ? wd[s][15:0] : 16'h0;
      kill[s] = (we[s] && rs[s] == 2'd3) ? wd[s][31:16] : 16'h0;
    end
    for (int s = 0; s < 2; s++) begin
      m_tx[s]  = ring[s] | (m_tx[s] & ~ack[1-s] & ~kill[s]);
      m_txe[s] = ack[1-s] | (m_txe[s] & ~ctxe[s] & ~ring[s]);
      m_rxf[s] = ring[1-s] | (m_rxf[s] & ~crxf[s]);
      if (we[s] && rs[s] == 2'd2) begin
        m_mtx[s] = wd[s][31:16];
        m_mrx[s] = wd[s][15:0];
      end
    end
    @(negedge clk);
    a_we = 1'b0; b_we = 1'b0;
  endtask

  task automatic wr(int s, logic [3:0] addr, logic [31:0] data);
    if (s == 0) op(1'b1, addr, data, 1'b0, 4'h0, 32'h0);
    else        op(1'b0, 4'h0, 32'h0, 1'b1, addr, data);
  endtask

  task automatic tick();
    @(posedge clk);
    m_irq[0] = irq_of(0);
    m_irq[1] = irq_of(1);
    @(negedge clk);
  endtask

  task automatic check_all(string tag);
    for (int r = 0; r < 4; r++) begin
      logic [31:0] ea, eb;
      a_addr = 4'(r * 4);
      b_addr = 4'(r * 4);
      #1;
      case (r)
        0: begin ea = {m_tx[0], m_tx[1]};   eb = {m_tx[1], m_tx[0]};   end
        1: begin ea = {m_txe[0], m_rxf[0]}; eb = {m_txe[1], m_rxf[1]}; end
        2: begin ea = {m_mtx[0], m_mrx[0]}; eb = {m_mtx[1], m_mrx[1]}; end
        default: begin ea = 32'h0; eb = 32'h0; end
      endcase
      cmp(tag, $sformatf("A reg%0d", r), a_rd, ea);
      cmp(tag, $sformatf("B reg%0d", r), b_rd, eb);
    end
    cmp(tag, "A irq", {31'h0, a_irq}, {31'h0, m_irq[0]});
    cmp(tag, "B irq", {31'h0, b_irq}, {31'h0, m_irq[1]});
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    a_we = 0; b_we = 0; a_addr = 0; b_addr = 0; a_wd = 0; b_wd = 0;
    for (int s = 0; s < 2; s++) begin
      m_tx[s] = 0; m_txe[s] = 0; m_rxf[s] = 0; m_mtx[s] = 0; m_mrx[s] = 0; m_irq[s] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check_all("R1");

    // R11: sweep every channel in both directions: ring, release, clear empty
    for (int s = 0; s < 2; s++) begin
      for (int c = 0; c < 16; c++) begin
        wr(s, 4'h0, 32'h1 << (16 + c));
        check_all("R3");
        wr(1 - s, 4'h4, 32'h1 << c);
        check_all("R5");
        wr(s, 4'h4, 32'h1 << (16 + c));
        check_all("R4");
      end
    end

    // R2: zero writes and writes to the view half do nothing
    wr(0, 4'h0, 32'h0000_FFFF);
    check_all("R2");
    wr(0, 4'h0, 32'h0000_0000);
    check_all("R2");
    // R4: status write of 0 leaves a pending flag
    wr(1, 4'h0, 32'h0004_0000);
    wr(0, 4'h4, 32'h0000_0000);
    check_all("R4");
    // R5: clearing an already clear flag releases nothing
    wr(1, 4'h4, 32'h0000_0002);
    check_all("R5");

    // R6: mask readback
    wr(1, 4'h8, 32'hA5A5_5A5A);
    check_all("R6");
    wr(1, 4'h8, 32'h0000_0000);

    // R7: registered interrupt, rises and falls one cycle late
    wr(0, 4'h8, 32'h0000_0004);
    check_all("R7");
    tick();
    cmp("R7", "A irq pending", {31'h0, a_irq}, 32'h1);
    check_all("R7");
    wr(1, 4'h0, 32'h0020_0000);     // masked channel 5
    tick();
    check_all("R7");
    wr(0, 4'h4, 32'h0000_0004);     // release ch2 on A
    cmp("R7", "A irq one cycle late", {31'h0, a_irq}, 32'h1);
    tick();
    cmp("R7", "A irq dropped", {31'h0, a_irq}, 32'h0);
    check_all("R7");
    wr(1, 4'h8, 32'hFFFF_0000);     // B send-empty enables
    wr(0, 4'h4, 32'h0000_0020);     // A releases ch5 -> B empty
    tick();
    cmp("R7", "B irq on empty", {31'h0, b_irq}, 32'h1);
    check_all("R7");
    wr(1, 4'h4, 32'hFFFF_0000);
    tick();
    check_all("R7");
    wr(0, 4'h8, 32'h0);
    wr(1, 4'h8, 32'h0);
    wr(0, 4'h4, 32'hFFFF_FFFF);
    wr(1, 4'h4, 32'hFFFF_FFFF);
    tick();
    check_all("R1");

    // R8: forced send clear keeps the peer flag
    wr(0, 4'h0, 32'h1000_0000);
    wr(0, 4'hC, 32'h0000_FFFF);     // zero in upper half: no effect
    check_all("R8");
    wr(0, 4'hC, 32'h1000_0000);
    check_all("R8");

    // R9: ring and release on ch3 collide
    wr(0, 4'h0, 32'h0008_0000);
    wr(0, 4'hC, 32'h0008_0000);
    op(1'b1, 4'h0, 32'h0008_0000, 1'b1, 4'h4, 32'h0000_0008);
    check_all("R9");
    // R10: ring of busy ch3 leaves empty status set
    wr(0, 4'h0, 32'h0008_0000);
    check_all("R10");
    // R9: empty clear collides with release
    op(1'b1, 4'h4, 32'h0008_0000, 1'b1, 4'h4, 32'h0000_0008);
    check_all("R9");
    // R9: flag clear collides with a new ring from the peer
    wr(0, 4'h4, 32'hFFFF_FFFF);
    wr(1, 4'h4, 32'hFFFF_FFFF);
    wr(0, 4'h0, 32'h0100_0000);
    wr(0, 4'hC, 32'h0100_0000);
    op(1'b1, 4'h0, 32'h0100_0000, 1'b1, 4'h4, 32'h0000_0100);
    check_all("R9");
    // R10 and R11: mixed multi-channel traffic both ways
    op(1'b1, 4'h0, 32'hFFFF_0000, 1'b1, 4'h0, 32'h00F0_0000);
    check_all("R11");
    op(1'b1, 4'h4, 32'h0000_00F0, 1'b1, 4'h4, 32'h0000_5555);
    check_all("R11");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule